// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This block sits between a 64-bit integer/floating-point pipeline and a byte-addressable data memory. For each memory operation it receives a base register value, a 16-bit signed displacement, an access size, a signed/unsigned flag, a byte-order mode bit and, depending on direction, either the store data or the 64-bit memory word read for a load. It forms the effective address and checks that the access is aligned to its own size.

For a store it produces an 8-bit lane write mask and the store data moved onto the addressed byte lanes. For a load it picks the addressed bytes out of the memory word and then widens them to 64 bits with either sign or zero extension. Single-precision floating-point transfers use the word size, and double-precision ones use the double-word size. An absolute address is formed by passing a zero base.

A misaligned access raises a fault flag in place of the access. All results are registered, so they appear one clock after the request. The load result register only changes on an aligned load.

Top module: `lsu_align_unit`

## Requirements
- R1: The effective address is `base + sign_extend(disp)` computed modulo 2^64. The 16-bit displacement is sign-extended before the addition, and a zero base gives an absolute address.
- R2: `req_size` encodes the access width as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. The fault flag is set exactly when the low address bits selected by (bytes − 1) are not all zero, so byte accesses never fault.
- R3: On a fault, `rsp_be` and `rsp_wdata` are all zero and `load_data` keeps its previous value.
- R4: For an aligned store with `big_endian` = 0 at byte offset o (address bits 2:0) with n bytes, `rsp_be` bits o..o+n−1 are set. Byte k of `req_wdata` (k = 0 is the least significant byte) appears on lane o+k of `rsp_wdata` (lane L is bits 8L+7..8L), and every other lane is zero.
- R5: For an aligned store with `big_endian` = 1, the address byte o+j is held on lane 7−(o+j), and that address receives data byte n−1−j. As a result the mask is the little-endian mask mirrored.
- R6: For an aligned load with `req_unsigned` = 0, `load_data` is the assembled value sign-extended to 64 bits.
- R7: For an aligned load with `req_unsigned` = 1, the assembled value is zero-extended to 64 bits.
- R8: For an aligned load, the byte of `req_rdata` on the lane that holds address o+j becomes byte j (little-endian, lane o+j) or byte n−1−j (big-endian, lane 7−(o+j)) of the loaded value.
- R9: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. Loads give `rsp_be` = 0 and `rsp_wdata` = 0. When `rsp_valid` is low, `rsp_be` is zero.
- R10: During and right after synchronous reset, `rsp_valid`, `rsp_fault` and `rsp_be` are 0, and `load_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code (R2) |
| req_unsigned | input | 1 | Zero-extend loads when 1 |
| big_endian | input | 1 | Byte-order mode: 1 = big-endian |
| req_base | input | 64 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_wdata | input | 64 | Store data, right-aligned |
| req_rdata | input | 64 | Memory word for a load |
| rsp_valid | output | 1 | Registered response valid |
| rsp_addr | output | 64 | Effective address |
| rsp_fault | output | 1 | Misalignment fault |
| rsp_be | output | 8 | Store lane write mask |
| rsp_wdata | output | 64 | Lane-placed store data |
| load_data | output | 64 | Extended load result (held) |

## Verification
The bench builds the unit with its default parameters: a 64-bit address, a 64-bit data word and a 16-bit displacement. These defaults put several cases within reach: address wrap-around past 2^64, the most negative displacements, and every lane offset of the eight-byte word for each of the four sizes in both byte orders. A scoreboard model places bytes address by address rather than by shifting. This gives a check of the mirrored big-endian lanes and the extension bit that does not depend on the lane-shift formula the design uses. Misaligned loads are placed between aligned loads to show that the held result survives.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    // number of bytes moved by an access of the given size
    function automatic logic [3:0] size_bytes(acc_size_e s);
        return 4'd1 << s;
    endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 16,
    parameter int OFS_W  = 3
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [DISP_W-1:0] disp_i,
    input  acc_size_e         size_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [OFS_W-1:0]  ofs_o,
    output logic              misalign_o
);
    logic [ADDR_W-1:0] disp_ext;
    logic [OFS_W-1:0]  low_mask;

    always_comb begin
        disp_ext   = {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
        addr_o     = base_i + disp_ext;
        ofs_o      = addr_o[OFS_W-1:0];
        low_mask   = (OFS_W'(1) << size_i) - OFS_W'(1);
        misalign_o = |(ofs_o & low_mask);
    end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane #(
    parameter int LANES = 8,
    parameter int OFS_W = 3
) (
    input  logic [OFS_W-1:0]   shift_i,
    input  logic [OFS_W:0]     nbytes_i,
    input  logic [LANES*8-1:0] wdata_i,
    output logic [LANES-1:0]   be_o,
    output logic [LANES*8-1:0] data_o
);
    logic [LANES*8-1:0] moved;
    logic [OFS_W+1:0]   lane_end;

    always_comb begin
        moved    = wdata_i << ({3'd0, shift_i} * 8);
        lane_end = {1'b0, nbytes_i} + (OFS_W+2)'(shift_i);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            be_o[i] = ((OFS_W+2)'(i) >= (OFS_W+2)'(shift_i)) &&
                      ((OFS_W+2)'(i) <  lane_end);
            data_o[i*8 +: 8] = be_o[i] ? moved[i*8 +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int OFS_W  = 3
) (
    input  logic [DATA_W-1:0] rdata_i,
    input  logic [OFS_W-1:0]  shift_i,
    input  acc_size_e         size_i,
    input  logic              unsigned_i,
    output logic [DATA_W-1:0] value_o
);
    logic [DATA_W-1:0] low;
    logic              sbit;

    always_comb begin
        low = rdata_i >> ({3'd0, shift_i} * 8);
        unique case (size_i)
            SZ_BYTE: begin
                sbit    = low[7] & ~unsigned_i;
                value_o = {{(DATA_W-8){sbit}}, low[7:0]};
            end
            SZ_HALF: begin
                sbit    = low[15] & ~unsigned_i;
                value_o = {{(DATA_W-16){sbit}}, low[15:0]};
            end
            SZ_WORD: begin
                sbit    = low[31] & ~unsigned_i;
                value_o = {{(DATA_W-32){sbit}}, low[31:0]};
            end
            default: begin
                sbit    = 1'b0;
                value_o = low;
            end
        endcase
    end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64,
    parameter int DISP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic              big_endian,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [DISP_W-1:0] req_disp,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] req_rdata,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_fault,
    output logic [DATA_W/8-1:0] rsp_be,
    output logic [DATA_W-1:0] rsp_wdata,
    output logic [DATA_W-1:0] load_data
);
    localparam int LANES = DATA_W / 8;
    localparam int OFS_W = $clog2(LANES);

    acc_size_e         size_c;
    logic [ADDR_W-1:0] addr_c;
    logic [OFS_W-1:0]  ofs_c;
    logic              mis_c;
    logic [OFS_W:0]    nbytes_c;
    logic [OFS_W-1:0]  shift_c;
    logic [LANES-1:0]  be_c;
    logic [DATA_W-1:0] wlane_c;
    logic [DATA_W-1:0] lval_c;
    logic              r_store;
    acc_size_e         r_size;

    always_comb begin
        size_c   = acc_size_e'(req_size);
        nbytes_c = (OFS_W+1)'(size_bytes(size_c));
        // big-endian: address offset o sits on lane LANES-1-o
        shift_c  = big_endian ? OFS_W'(LANES - int'(ofs_c) - int'(nbytes_c))
                              : ofs_c;
    end

    lsu_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .OFS_W(OFS_W)) u_agen (
        .base_i(req_base), .disp_i(req_disp), .size_i(size_c),
        .addr_o(addr_c), .ofs_o(ofs_c), .misalign_o(mis_c)
    );

    lsu_store_lane #(.LANES(LANES), .OFS_W(OFS_W)) u_st (
        .shift_i(shift_c), .nbytes_i(nbytes_c), .wdata_i(req_wdata),
        .be_o(be_c), .data_o(wlane_c)
    );

    lsu_load_extract #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_ld (
        .rdata_i(req_rdata), .shift_i(shift_c), .size_i(size_c),
        .unsigned_i(req_unsigned), .value_o(lval_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_fault <= 1'b0;
            rsp_be    <= '0;
            rsp_wdata <= '0;
            load_data <= '0;
            r_store   <= 1'b0;
            r_size    <= SZ_BYTE;
        end else begin
            rsp_valid <= req_valid;
            r_store   <= req_store;
            r_size    <= size_c;
            rsp_addr  <= req_valid ? addr_c : rsp_addr;
            rsp_fault <= req_valid & mis_c;
            rsp_be    <= (req_valid && req_store && !mis_c) ? be_c : '0;
            rsp_wdata <= (req_valid && req_store && !mis_c) ? wlane_c : '0;
            if (req_valid && !req_store && !mis_c)
                load_data <= lval_c;
        end
    end

    // R9
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    // R9
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    // R3
    fault_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_be == '0 && rsp_wdata == '0));
    // R3
    fault_keeps_load_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> $stable(load_data));
    // R2
    fault_only_on_resp_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> rsp_valid);
    // R4
    store_mask_width_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && r_store && !rsp_fault) |->
            ($countones(rsp_be) == int'(size_bytes(r_size))));
    // R9
    load_no_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (!rsp_valid || !r_store) |-> (rsp_be == '0));
endmodule

// File: tb/sim_lsu_align_unit.sv
module sim_lsu_align_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0, big_endian = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [63:0] req_base = '0, req_wdata = '0, req_rdata = '0;
    logic [15:0] req_disp = '0;
    logic        rsp_valid, rsp_fault;
    logic [63:0] rsp_addr, rsp_wdata, load_data;
    logic [7:0]  rsp_be;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        logic [63:0] addr;
        logic        fault;
        logic [7:0]  be;
        logic [63:0] wd;
        logic [63:0] ld;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [63:0] model_ld = '0;

    lsu_align_unit u0 (
        .clk, .rst, .req_valid, .req_store, .req_size, .req_unsigned, .big_endian,
        .req_base, .req_disp, .req_wdata, .req_rdata,
        .rsp_valid, .rsp_addr, .rsp_fault, .rsp_be, .rsp_wdata, .load_data
    );

    always #10ns clk = ~clk;   // 50 MHz

    task automatic drive(input bit st, input logic [1:0] sz, input bit uns, input bit big,
                         input logic [63:0] base, input logic [15:0] disp,
                         input logic [63:0] wd, input logic [63:0] rd, input string tag);
        exp_t e;
        int n;
        logic [2:0] o;
        logic [63:0] res;
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = uns;
        big_endian = big; req_base = base; req_disp = disp;
        req_wdata = wd; req_rdata = rd;
        n      = 1 << sz;
        e.addr = base + {{48{disp[15]}}, disp};
        o      = e.addr[2:0];
        e.fault = (e.addr & 64'(n - 1)) != 0;
        e.be = '0; e.wd = '0; res = '0;
        e.tag = tag;
        if (!e.fault) begin
            for (int j = 0; j < n; j++) begin
                int k, lane;
                k    = big ? (n - 1 - j) : j;
                lane = big ? (7 - (int'(o) + j)) : (int'(o) + j);
                if (st) begin
                    e.be[lane] = 1'b1;
                    e.wd[lane*8 +: 8] = wd[k*8 +: 8];
                end else begin
                    res[k*8 +: 8] = rd[lane*8 +: 8];
                end
            end
            if (!st) begin
                if (!uns && res[n*8-1])
                    for (int b = n*8; b < 64; b++) res[b] = 1'b1;
                model_ld = res;
            end
        end
        e.ld = model_ld;
        sb.push_back(e);
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    always @(negedge clk) begin
        if (!rst && rsp_valid && !done) begin
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL R9: unexpected response, actual valid=1 expected valid=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rsp_addr !== e.addr || rsp_fault !== e.fault || rsp_be !== e.be ||
                    rsp_wdata !== e.wd || load_data !== e.ld) begin
                    bad++;
                    $display("FAIL %s: actual addr=%h flt=%b be=%b wd=%h ld=%h expected addr=%h flt=%b be=%b wd=%h ld=%h",
                             e.tag, rsp_addr, rsp_fault, rsp_be, rsp_wdata, load_data,
                             e.addr, e.fault, e.be, e.wd, e.ld);
                end
            end
        end
    end

    initial begin
        #(20ns * 20000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        localparam logic [63:0] RD = 64'h8877_6655_44F3_2281;
        localparam logic [63:0] WD = 64'h0102_0304_A5B6_C7D8;
        repeat (3) @(negedge clk);
        // R10: reset state
        total++;
        if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0 || rsp_be !== 8'h00 || load_data !== '0) begin
            bad++;
            $display("FAIL R10: actual v=%b f=%b be=%b ld=%h expected 0", rsp_valid, rsp_fault, rsp_be, load_data);
        end
        @(negedge clk); rst = 1'b0;

        // R1: address formation
        drive(0, 2'd3, 0, 0, 64'h1000, 16'h0010, '0, RD, "R1");
        drive(0, 2'd3, 0, 0, 64'h2000, 16'hFFF8, '0, RD, "R1");
        drive(0, 2'd3, 0, 0, 64'h0, 16'h0040, '0, RD, "R1");
        drive(0, 2'd3, 0, 0, 64'hFFFF_FFFF_FFFF_FFF8, 16'h0010, '0, RD, "R1");
        drive(0, 2'd0, 0, 0, 64'h0000_0000_0001_0000, 16'h8000, '0, RD, "R1");
        // R4: little-endian stores
        drive(1, 2'd0, 0, 0, 64'h100, 16'h0005, WD, '0, "R4");
        drive(1, 2'd1, 0, 0, 64'h100, 16'h0002, WD, '0, "R4");
        drive(1, 2'd2, 0, 0, 64'h100, 16'h0004, WD, '0, "R4");
        drive(1, 2'd3, 0, 0, 64'h100, 16'h0000, WD, '0, "R4");
        // R5: big-endian stores
        drive(1, 2'd0, 0, 1, 64'h100, 16'h0005, WD, '0, "R5");
        drive(1, 2'd1, 0, 1, 64'h100, 16'h0002, WD, '0, "R5");
        drive(1, 2'd2, 0, 1, 64'h100, 16'h0004, WD, '0, "R5");
        drive(1, 2'd3, 0, 1, 64'h100, 16'h0000, WD, '0, "R5");
        // R6: signed little-endian loads
        drive(0, 2'd0, 0, 0, 64'h200, 16'h0002, '0, RD, "R6");
        drive(0, 2'd1, 0, 0, 64'h200, 16'h0006, '0, RD, "R6");
        drive(0, 2'd2, 0, 0, 64'h200, 16'h0004, '0, RD, "R6");
        drive(0, 2'd0, 0, 0, 64'h200, 16'h0000, '0, RD, "R6");
        // R7: unsigned loads
        drive(0, 2'd0, 1, 0, 64'h200, 16'h0002, '0, RD, "R7");
        drive(0, 2'd1, 1, 0, 64'h200, 16'h0006, '0, RD, "R7");
        drive(0, 2'd2, 1, 0, 64'h200, 16'h0004, '0, RD, "R7");
        // R8: big-endian loads
        drive(0, 2'd0, 0, 1, 64'h200, 16'h0001, '0, RD, "R8");
        drive(0, 2'd1, 0, 1, 64'h200, 16'h0004, '0, RD, "R8");
        drive(0, 2'd2, 1, 1, 64'h200, 16'h0000, '0, RD, "R8");
        drive(0, 2'd2, 0, 1, 64'h200, 16'h0004, '0, RD, "R8");
        // R2 / R3: misaligned accesses
        drive(1, 2'd1, 0, 0, 64'h300, 16'h0001, WD, '0, "R2");
        drive(0, 2'd2, 0, 0, 64'h300, 16'h0002, '0, RD, "R3");
        drive(0, 2'd3, 0, 1, 64'h300, 16'h0004, '0, RD, "R3");
        drive(1, 2'd2, 0, 1, 64'h300, 16'h0006, WD, '0, "R3");
        drive(0, 2'd0, 1, 0, 64'h300, 16'h0007, '0, RD, "R2");
        // R9: gap then isolated request
        idle(3);
        drive(0, 2'd1, 0, 0, 64'h400, 16'h0002, '0, RD, "R9");
        idle(1);
        drive(1, 2'd0, 0, 1, 64'h400, 16'h0003, WD, '0, "R9");
        idle(4);
        // R9: every request produced a response
        total++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL R9: actual pending=%0d expected pending=0", sb.size());
        end
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule